// File: doc/BRIEF.md
# Capacitor Charge State Balancer

This block belongs to the cell controller of a seven-level converter leg that has two floating capacitors. Once per switching period it works out whether each capacitor is charging, discharging or floating. It bases that decision on the output level the leg is producing and on the direction of the phase current. It then forms one signed amplitude correction, which is added to the modulating wave so that the capacitor being adjusted moves back toward its reference. The errors it receives already come from upstream regulators, with each error defined as reference minus measurement. Only one capacitor ever carries current in a given level, so its error alone sets the size of the correction. The correction is limited to a magnitude that software programs.

A two-state controller sequences the work. In `PH_IDLE` the block waits for the sample strobe. A strobe in `PH_IDLE` latches every input and moves to `PH_EVAL` (transition *accept*). `PH_EVAL` registers the new status codes and the correction, then returns to `PH_IDLE` without condition (transition *publish*). If there is no strobe, `PH_IDLE` stays where it is (transition *wait*). The outputs keep their values between updates.

Top module: `cap_charge_balancer`

## Requirements
- R1: During reset and directly after it, both status outputs are 2'b00 (floating) and the trim is 0.
- R2: A strobe seen at a rising edge in `PH_IDLE` latches level, current sign, both errors and the limit. The results appear after the next rising edge and hold until the next accepted strobe.
- R3: A strobe that arrives while the block is in `PH_EVAL` has no effect. The results then reflect only the strobe that was accepted.
- R4: Status codes are 2'b00 floating, 2'b01 charging and 2'b10 discharging. With positive current (sign input 2'b01) the codes per level are: level 6 gives cap1 discharging and cap2 floating; level 5 gives cap1 floating and cap2 discharging; level 3 gives cap1 floating and cap2 charging; level 2 gives cap1 charging and cap2 floating.
- R5: With negative current (sign input 2'b10), every charging and discharging entry of R4 is exchanged, and floating entries stay floating.
- R6: Levels 1, 4 and 7 leave both capacitors floating with trim 0. The unused level code 0 is treated the same way.
- R7: A current sign input of 2'b00 or 2'b11 means zero current. Both capacitors then float and the trim is 0.
- R8: For a discharging capacitor the trim is its error. An overvoltage (negative error) therefore lowers the amplitude.
- R9: For a charging capacitor the trim is the negated error. An undervoltage (positive error) therefore lowers the amplitude.
- R10: The trim is saturated to the range from minus the latched limit to plus the latched limit, with the limit read as unsigned.
- R11: At no time are both capacitors shown as non-floating together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_i | input | 1 | Sample strobe, once per switching period |
| level_i | input | 3 | Output level index, 1 (lowest) to 7 (highest) |
| isign_i | input | 2 | Current direction: 01 positive, 10 negative, otherwise zero |
| err1_i | input | ERR_W | Signed error of capacitor 1, reference minus measured |
| err2_i | input | ERR_W | Signed error of capacitor 2, reference minus measured |
| trim_lim_i | input | ERR_W | Unsigned saturation limit for the trim |
| c1_state_o | output | 2 | Capacitor 1 status code |
| c2_state_o | output | 2 | Capacitor 2 status code |
| trim_o | output | ERR_W+1 | Signed amplitude trim |

## Verification
Two registers sit between a strobe and the results: the input latch at the accepting edge, and the output register at the following edge in `PH_EVAL`. The status codes and the trim therefore change together, one full cycle after the accepting edge. The bench driver records, for every strobe, the cycle number that is two rising edges after the falling edge where it drove the strobe. The monitor compares only at the falling edge of that cycle, so it never samples during an update. For an ignored strobe, the item is due one cycle later and expects the earlier result.

// File: rtl/cbal_pkg.sv
package cbal_pkg;

    localparam int NCAP  = 2;
    localparam int LVL_W = 3;

    localparam logic [1:0] SIGN_POS = 2'b01;
    localparam logic [1:0] SIGN_NEG = 2'b10;

    typedef enum logic [1:0] {
        CAP_SUSPEND   = 2'b00,
        CAP_CHARGE    = 2'b01,
        CAP_DISCHARGE = 2'b10
    } cap_state_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_EVAL = 1'b1
    } phase_e;

    // Reverse the direction of a transfer; a floating capacitor stays floating.
    function automatic cap_state_e flip_dir(input cap_state_e s);
        case (s)
            CAP_CHARGE:    return CAP_DISCHARGE;
            CAP_DISCHARGE: return CAP_CHARGE;
            default:       return CAP_SUSPEND;
        endcase
    endfunction

endpackage

// File: rtl/cbal_state_lut.sv
module cbal_state_lut
    import cbal_pkg::*;
(
    input  logic [LVL_W-1:0] level_i,
    input  logic [1:0]       isign_i,
    output cap_state_e       st_o [NCAP]
);

    // Status with the current flowing in the positive direction.
    cap_state_e pos_st [NCAP];

    always_comb begin
        for (int k = 0; k < NCAP; k++) begin
            pos_st[k] = CAP_SUSPEND;
        end
        case (level_i)
            LVL_W'(6): pos_st[0] = CAP_DISCHARGE;
            LVL_W'(5): pos_st[1] = CAP_DISCHARGE;
            LVL_W'(3): pos_st[1] = CAP_CHARGE;
            LVL_W'(2): pos_st[0] = CAP_CHARGE;
            default:   ;
        endcase
    end

    // Apply the current direction to each capacitor's entry.
    for (genvar g = 0; g < NCAP; g++) begin : g_dir
        always_comb begin
            case (isign_i)
                SIGN_POS: st_o[g] = pos_st[g];
                SIGN_NEG: st_o[g] = flip_dir(pos_st[g]);
                default:  st_o[g] = CAP_SUSPEND;
            endcase
        end
    end

endmodule

// File: rtl/cbal_trim_calc.sv
module cbal_trim_calc
    import cbal_pkg::*;
#(
    parameter int ERR_W = 12
) (
    input  cap_state_e               st_i  [NCAP],
    input  logic signed [ERR_W-1:0]  err_i [NCAP],
    input  logic        [ERR_W-1:0]  lim_i,
    output logic signed [ERR_W:0]    trim_o
);

    localparam int OUT_W = ERR_W + 1;
    localparam int SUM_W = OUT_W + $clog2(NCAP);

    logic signed [SUM_W-1:0] contrib [NCAP];
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] lim_s;
    logic signed [SUM_W-1:0] sat;

    // Each capacitor's share: its error when discharging, the negated error when charging.
    for (genvar g = 0; g < NCAP; g++) begin : g_cap
        logic signed [SUM_W-1:0] ext;
        assign ext        = SUM_W'(err_i[g]);
        assign contrib[g] = (st_i[g] == CAP_DISCHARGE) ? ext  :
                            (st_i[g] == CAP_CHARGE)    ? -ext :
                                                         '0;
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < NCAP; k++) begin
            sum = sum + contrib[k];
        end
    end

    assign lim_s = $signed(SUM_W'(lim_i));

    always_comb begin
        if (sum > lim_s) begin
            sat = lim_s;
        end else if (sum < -lim_s) begin
            sat = -lim_s;
        end else begin
            sat = sum;
        end
    end

    assign trim_o = OUT_W'(sat);

endmodule

// File: rtl/cap_charge_balancer.sv
module cap_charge_balancer
    import cbal_pkg::*;
#(
    parameter int ERR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_i,
    input  logic [LVL_W-1:0]        level_i,
    input  logic [1:0]              isign_i,
    input  logic signed [ERR_W-1:0] err1_i,
    input  logic signed [ERR_W-1:0] err2_i,
    input  logic [ERR_W-1:0]        trim_lim_i,
    output logic [1:0]              c1_state_o,
    output logic [1:0]              c2_state_o,
    output logic signed [ERR_W:0]   trim_o
);

    phase_e ph_q;
    phase_e ph_d;

    logic [LVL_W-1:0]        lvl_q;
    logic [1:0]              sgn_q;
    logic signed [ERR_W-1:0] err_q [NCAP];
    logic [ERR_W-1:0]        lim_q;

    cap_state_e              st_w  [NCAP];
    logic signed [ERR_W:0]   trim_w;
    cap_state_e              st_q  [NCAP];
    logic signed [ERR_W:0]   trim_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Transitions: wait, accept, publish
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: ph_d = sample_i ? PH_EVAL : PH_IDLE;
            PH_EVAL: ph_d = PH_IDLE;
        endcase
    end

    // Input latch on an accepted strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            sgn_q <= '0;
            lim_q <= '0;
            for (int k = 0; k < NCAP; k++) begin
                err_q[k] <= '0;
            end
        end else if (ph_q == PH_IDLE && sample_i) begin
            lvl_q    <= level_i;
            sgn_q    <= isign_i;
            lim_q    <= trim_lim_i;
            err_q[0] <= err1_i;
            err_q[1] <= err2_i;
        end
    end

    cbal_state_lut u_lut (
        .level_i (lvl_q),
        .isign_i (sgn_q),
        .st_o    (st_w)
    );

    cbal_trim_calc #(
        .ERR_W (ERR_W)
    ) u_trim (
        .st_i   (st_w),
        .err_i  (err_q),
        .lim_i  (lim_q),
        .trim_o (trim_w)
    );

    // Output register, written only while evaluating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NCAP; k++) begin
                st_q[k] <= CAP_SUSPEND;
            end
            trim_q <= '0;
        end else if (ph_q == PH_EVAL) begin
            for (int k = 0; k < NCAP; k++) begin
                st_q[k] <= st_w[k];
            end
            trim_q <= trim_w;
        end
    end

    assign c1_state_o = st_q[0];
    assign c2_state_o = st_q[1];
    assign trim_o     = trim_q;

endmodule

// File: rtl/cap_charge_balancer_chk.sv
module cap_charge_balancer_chk #(
    parameter int ERR_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sample_i,
    input cbal_pkg::phase_e      ph_q,
    input logic [1:0]            c1_state_o,
    input logic [1:0]            c2_state_o,
    input logic signed [ERR_W:0] trim_o,
    input logic [ERR_W-1:0]      lim_q
);

    import cbal_pkg::*;

    // R2
    strobe_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_IDLE && sample_i) |=> (ph_q == PH_EVAL));

    // R3
    eval_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_EVAL) |=> (ph_q == PH_IDLE));

    // R2
    output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_IDLE) |=> ($stable(c1_state_o) && $stable(c2_state_o) && $stable(trim_o)));

    // R11
    single_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((c1_state_o != 2'b00) && (c2_state_o != 2'b00)));

    // R6
    float_zero_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c1_state_o == 2'b00 && c2_state_o == 2'b00) |-> (trim_o == '0));

    // R10
    trim_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_EVAL) |=> (($signed(trim_o) <= $signed({1'b0, lim_q})) &&
                               ($signed(trim_o) >= -$signed({1'b0, lim_q}))));

endmodule

bind cap_charge_balancer cap_charge_balancer_chk #(
    .ERR_W (ERR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_i   (sample_i),
    .ph_q       (ph_q),
    .c1_state_o (c1_state_o),
    .c2_state_o (c2_state_o),
    .trim_o     (trim_o),
    .lim_q      (lim_q)
);

// File: tb/cap_charge_balancer_tb_top.sv
`timescale 1ns/1ps
module cap_charge_balancer_tb_top;

    localparam int ERR_W = 12;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    sample = 1'b0;
    logic [2:0]              lvl = '0;
    logic [1:0]              sgn = '0;
    logic signed [ERR_W-1:0] e1 = '0;
    logic signed [ERR_W-1:0] e2 = '0;
    logic [ERR_W-1:0]        lim = '0;
    logic [1:0]              s1;
    logic [1:0]              s2;
    logic signed [ERR_W:0]   trim;

    always #2.5 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    typedef struct {
        int         due;
        logic [1:0] s1;
        logic [1:0] s2;
        int         trim;
        string      req;
    } exp_t;

    exp_t       sb[$];
    logic [1:0] last_s1 = 2'b00;
    logic [1:0] last_s2 = 2'b00;
    int         last_trim = 0;

    cap_charge_balancer #(.ERR_W(ERR_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (sample),
        .level_i    (lvl),
        .isign_i    (sgn),
        .err1_i     (e1),
        .err2_i     (e2),
        .trim_lim_i (lim),
        .c1_state_o (s1),
        .c2_state_o (s2),
        .trim_o     (trim)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Expected status from R4, R5, R6, R7
    function automatic logic [1:0] exp_state(input int cap, input int l, input logic [1:0] sg);
        logic [1:0] p;
        p = 2'b00;
        if (cap == 0 && l == 6) p = 2'b10;
        if (cap == 0 && l == 2) p = 2'b01;
        if (cap == 1 && l == 5) p = 2'b10;
        if (cap == 1 && l == 3) p = 2'b01;
        if (sg == 2'b01) return p;
        if (sg == 2'b10) return (p == 2'b01) ? 2'b10 : (p == 2'b10) ? 2'b01 : 2'b00;
        return 2'b00;
    endfunction

    // Expected trim from R8, R9, R10
    function automatic int exp_trim(input logic [1:0] a, input logic [1:0] b,
                                    input int x1, input int x2, input int lm);
        int t;
        t = 0;
        if (a == 2'b10) t += x1;
        if (a == 2'b01) t -= x1;
        if (b == 2'b10) t += x2;
        if (b == 2'b01) t -= x2;
        if (t > lm) t = lm;
        if (t < -lm) t = -lm;
        return t;
    endfunction

    task automatic send(input int l, input logic [1:0] sg, input int x1, input int x2,
                        input int lm, input string req, input bit taken);
        exp_t it;
        @(negedge clk);
        lvl    = 3'(l);
        sgn    = sg;
        e1     = ERR_W'(x1);
        e2     = ERR_W'(x2);
        lim    = ERR_W'(lm);
        sample = 1'b1;
        if (taken) begin
            last_s1   = exp_state(0, l, sg);
            last_s2   = exp_state(1, l, sg);
            last_trim = exp_trim(last_s1, last_s2, x1, x2, lm);
        end
        it.due  = cyc + 2;
        it.s1   = last_s1;
        it.s2   = last_s2;
        it.trim = last_trim;
        it.req  = req;
        sb.push_back(it);
    endtask

    task automatic quiet(input int n);
        repeat (n) begin
            @(negedge clk);
            sample = 1'b0;
        end
    endtask

    task automatic hold_check(input string req);
        exp_t it;
        it.due  = cyc;
        it.s1   = last_s1;
        it.s2   = last_s2;
        it.trim = last_trim;
        it.req  = req;
        sb.push_back(it);
    endtask

    // Monitor: pop an item when its cycle is due and compare
    always @(negedge clk) begin
        exp_t it;
        if (sb.size() > 0 && sb[0].due <= cyc) begin
            it = sb.pop_front();
            checks++;
            if (s1 !== it.s1 || s2 !== it.s2 || int'(trim) != it.trim) begin
                fails++;
                $display("FAIL %s: got s1=%0d s2=%0d trim=%0d expected s1=%0d s2=%0d trim=%0d",
                         it.req, s1, s2, int'(trim), it.s1, it.s2, it.trim);
            end
        end
    end

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got run still active, expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (s1 !== 2'b00 || s2 !== 2'b00 || trim !== '0) begin
            fails++;
            $display("FAIL R1: got s1=%0d s2=%0d trim=%0d expected s1=0 s2=0 trim=0", s1, s2, int'(trim));
        end
        rst_n = 1'b1;
        quiet(2);
        hold_check("R1 after reset");
        quiet(2);

        // R4 positive current, with R8/R9 trim and R11 single active
        send(6, 2'b01, -100, 7, 2000, "R4 R8 R11 level6 pos", 1); quiet(3);
        send(5, 2'b01, 30, 55, 2000, "R4 R8 R11 level5 pos", 1);  quiet(3);
        send(3, 2'b01, 30, -40, 2000, "R4 R9 level3 pos", 1);     quiet(3);
        send(2, 2'b01, 200, 9, 2000, "R4 R9 level2 pos", 1);      quiet(3);

        // R5 negative current swaps direction
        send(6, 2'b10, -100, 7, 2000, "R5 R9 level6 neg", 1);     quiet(3);
        send(5, 2'b10, 30, 55, 2000, "R5 R9 level5 neg", 1);      quiet(3);
        send(3, 2'b10, 30, -40, 2000, "R5 R8 level3 neg", 1);     quiet(3);
        send(2, 2'b10, 200, 9, 2000, "R5 R8 level2 neg", 1);      quiet(3);

        // R6 no adjustment at extremes, zero, and unused code
        send(1, 2'b01, 300, 300, 2000, "R6 level1", 1);           quiet(3);
        send(4, 2'b10, 300, -300, 2000, "R6 level4", 1);          quiet(3);
        send(7, 2'b01, -300, 300, 2000, "R6 level7", 1);          quiet(3);
        send(0, 2'b10, 300, 300, 2000, "R6 level0", 1);           quiet(3);

        // R7 zero current
        send(6, 2'b00, -500, 0, 2000, "R7 sign00", 1);            quiet(3);
        send(2, 2'b11, 500, 0, 2000, "R7 sign11", 1);             quiet(3);

        // R10 saturation boundaries
        send(2, 2'b01, -2048, 0, 1000, "R10 clamp high", 1);      quiet(3);
        send(6, 2'b01, -2048, 0, 1000, "R10 clamp low", 1);       quiet(3);
        send(6, 2'b01, 500, 0, 0, "R10 zero limit", 1);           quiet(3);
        send(2, 2'b01, -2048, 0, 4095, "R10 full range", 1);      quiet(3);
        send(5, 2'b01, 0, -1500, 1500, "R10 exact limit", 1);     quiet(3);

        // R3 strobe during evaluation is ignored
        send(6, 2'b01, -77, 0, 2000, "R3 accepted", 1);
        send(2, 2'b10, 999, 0, 2000, "R3 ignored strobe", 0);
        quiet(5);
        // R2 results hold without a strobe
        hold_check("R2 hold");
        quiet(3);

        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R2: got %0d pending items expected 0", sb.size());
        end
        finish_run();
    end

endmodule